// File: doc/BRIEF.md
# Compact 8-bit Stack Processor Core

This block is a small 8-bit processor with one 256-byte memory that holds both program and data, and a file of eight 8-bit general registers. Register R7 doubles as the stack pointer. The core runs a six-instruction set: load immediate, print a register, multiply, push, pop and halt. Any other opcode halts the core and raises an error flag.

Memory is filled through a preload port, and only while reset is held. After reset is released the core fetches from address 0. Each instruction takes a fetch cycle, one cycle per operand byte and an execute cycle. Push and pop add one more memory cycle. The print instruction puts a register value on an output bus, together with a strobe that is high for one cycle.

Top module: `stack_cpu8`

## Requirements
- R1: While `rst` is high, a preload write (`load_we`) stores `load_data` at `load_addr`. While `rst` is low, the preload port is ignored. Memory contents survive reset.
- R2: During and right after reset, PC is 0, R7 holds 0xF4, every other register holds 0, and `halted`, `error` and `print_valid` are low.
- R3: The number of operand bytes is taken from opcode bits 7:6. After each instruction, PC advances by one plus that count.
- R4: Opcode 0x82 takes a register index and an immediate byte, and writes the immediate into that register. A register index is always the low 3 bits of its operand byte.
- R5: Opcode 0x47 takes a register index. It drives that register's value on `print_data` with `print_valid` high for exactly one cycle.
- R6: Opcode 0xA2 takes indices A and B. It writes the low 8 bits of A×B into register A.
- R7: Opcode 0x45 takes a register index. It decrements R7 first, then stores the named register at address R7.
- R8: Opcode 0x46 takes a register index. It loads the byte at address R7 into the named register, then increments R7.
- R9: Opcode 0x01 raises `halted`. `halted` stays high until reset, and no print follows it.
- R10: Any other opcode raises both `halted` and `error`, and no later instruction is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| load_we | input | 1 | Preload write enable |
| load_addr | input | 8 | Preload address |
| load_data | input | 8 | Preload byte |
| print_valid | output | 1 | One-cycle strobe for a print |
| print_data | output | 8 | Printed register value |
| halted | output | 1 | Core stopped; held until reset |
| error | output | 1 | Stopped on an unknown opcode |

## Verification
The bench builds the core with its default parameters: 8-bit data and addresses, eight registers, R7 as stack pointer and 0xF4 as the initial stack value. With these values the programs reach a full memory image. They include a product that overflows 8 bits, stack traffic just below 0xF4 that returns R7 to its start value, an unknown opcode followed by a print that must never appear, and a preload attempt while running that must leave the rerun output unchanged.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int NREGS   = 8;
    localparam int SP_IDX  = 7;
    localparam logic [DATA_W-1:0] SP_INIT = 8'hF4;

    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t OP_LDI  = 8'h82;
    localparam byte_t OP_PRN  = 8'h47;
    localparam byte_t OP_MUL  = 8'hA2;
    localparam byte_t OP_PUSH = 8'h45;
    localparam byte_t OP_POP  = 8'h46;
    localparam byte_t OP_HLT  = 8'h01;

    typedef enum logic [2:0] {
        S_FETCH, S_OPA, S_OPB, S_EXEC, S_MEM, S_HALT
    } state_t;

    function automatic logic [1:0] op_count(byte_t op);
        return op[7:6];
    endfunction

    function automatic byte_t mul_lo(byte_t a, byte_t b);
        logic [2*DATA_W-1:0] p;
        p = a * b;
        return p[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
    parameter int DATA_W = cpu8_pkg::DATA_W,
    parameter int ADDR_W = cpu8_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
    parameter int DATA_W = cpu8_pkg::DATA_W,
    parameter int NREGS  = cpu8_pkg::NREGS,
    parameter int SP_IDX = cpu8_pkg::SP_IDX,
    parameter logic [DATA_W-1:0] SP_INIT = cpu8_pkg::SP_INIT,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] ra,
    output logic [DATA_W-1:0] rb,
    output logic [DATA_W-1:0] sp
);
    logic [DATA_W-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] INIT = (i == SP_IDX) ? SP_INIT : '0;
        always_ff @(posedge clk) begin
            if (rst) regs[i] <= INIT;
            else if (we && widx == IDX_W'(i)) regs[i] <= wdata;
        end
    end

    assign ra = regs[ra_idx];
    assign rb = regs[rb_idx];
    assign sp = regs[SP_IDX];
endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
    import cpu8_pkg::*;
#(
    parameter int NREGS  = cpu8_pkg::NREGS,
    parameter int SP_IDX = cpu8_pkg::SP_IDX,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_t            mem_rdata,
    output byte_t            mem_addr,
    output logic             mem_we,
    output byte_t            mem_wdata,
    output logic [IDX_W-1:0] ra_idx,
    output logic [IDX_W-1:0] rb_idx,
    input  byte_t            rf_ra,
    input  byte_t            rf_rb,
    input  byte_t            rf_sp,
    output logic             rf_we,
    output logic [IDX_W-1:0] rf_widx,
    output byte_t            rf_wdata,
    output logic             print_valid,
    output byte_t            print_data,
    output logic             halted,
    output logic             error
);
    state_t state;
    byte_t  pc, ir, opa, opb;

    assign ra_idx = opa[IDX_W-1:0];
    assign rb_idx = opb[IDX_W-1:0];
    assign halted = (state == S_HALT);

    always_comb begin
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = rf_ra;
        rf_we     = 1'b0;
        rf_widx   = ra_idx;
        rf_wdata  = opb;
        if (state == S_EXEC) begin
            unique case (ir)
                OP_LDI:  rf_we = 1'b1;
                OP_MUL:  begin rf_we = 1'b1; rf_wdata = mul_lo(rf_ra, rf_rb); end
                OP_POP:  begin mem_addr = rf_sp; rf_we = 1'b1; rf_wdata = mem_rdata; end
                OP_PUSH: begin rf_we = 1'b1; rf_widx = IDX_W'(SP_IDX); rf_wdata = rf_sp - 8'd1; end
                default: ;
            endcase
        end else if (state == S_MEM) begin
            if (ir == OP_PUSH) begin
                mem_addr = rf_sp;
                mem_we   = 1'b1;
            end else begin
                rf_we    = 1'b1;
                rf_widx  = IDX_W'(SP_IDX);
                rf_wdata = rf_sp + 8'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_FETCH;
            pc          <= '0;
            ir          <= '0;
            opa         <= '0;
            opb         <= '0;
            print_valid <= 1'b0;
            print_data  <= '0;
            error       <= 1'b0;
        end else begin
            print_valid <= 1'b0;
            unique case (state)
                S_FETCH: begin
                    ir    <= mem_rdata;
                    pc    <= pc + 8'd1;
                    state <= (op_count(mem_rdata) == 2'd0) ? S_EXEC : S_OPA;
                end
                S_OPA: begin
                    opa   <= mem_rdata;
                    pc    <= pc + 8'd1;
                    state <= (op_count(ir) == 2'd2) ? S_OPB : S_EXEC;
                end
                S_OPB: begin
                    opb   <= mem_rdata;
                    pc    <= pc + 8'd1;
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    unique case (ir)
                        OP_LDI, OP_MUL: state <= S_FETCH;
                        OP_PRN: begin
                            print_valid <= 1'b1;
                            print_data  <= rf_ra;
                            state       <= S_FETCH;
                        end
                        OP_PUSH, OP_POP: state <= S_MEM;
                        OP_HLT:  state <= S_HALT;
                        default: begin
                            error <= 1'b1;
                            state <= S_HALT;
                        end
                    endcase
                end
                S_MEM:   state <= S_FETCH;
                default: state <= S_HALT;
            endcase
        end
    end

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (pc == 8'd0 && !halted && !error && !print_valid));
    assert_print_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        print_valid |=> !print_valid);
    assert_push_dec_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && ir == OP_PUSH) |=> rf_sp == 8'($past(rf_sp) - 8'd1));
    assert_pop_inc_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_MEM && ir == OP_POP) |=> rf_sp == 8'($past(rf_sp) + 8'd1));
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !print_valid));
    assert_error_halts_R10: assert property (@(posedge clk) disable iff (rst)
        error |-> halted);
endmodule

// File: rtl/stack_cpu8.sv
module stack_cpu8
    import cpu8_pkg::*;
#(
    parameter int NREGS  = cpu8_pkg::NREGS,
    parameter int SP_IDX = cpu8_pkg::SP_IDX,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_we,
    input  logic [7:0] load_addr,
    input  logic [7:0] load_data,
    output logic       print_valid,
    output logic [7:0] print_data,
    output logic       halted,
    output logic       error
);
    byte_t            core_addr, core_wdata, mem_rdata;
    logic             core_we;
    logic             m_we;
    byte_t            m_waddr, m_wdata;
    logic [IDX_W-1:0] ra_idx, rb_idx, rf_widx;
    byte_t            rf_ra, rf_rb, rf_sp, rf_wdata;
    logic             rf_we;

    assign m_we    = rst ? load_we   : core_we;
    assign m_waddr = rst ? load_addr : core_addr;
    assign m_wdata = rst ? load_data : core_wdata;

    cpu8_mem u_mem (
        .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
        .raddr(core_addr), .rdata(mem_rdata)
    );

    cpu8_regfile #(.NREGS(NREGS), .SP_IDX(SP_IDX)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
        .ra_idx(ra_idx), .rb_idx(rb_idx), .ra(rf_ra), .rb(rf_rb), .sp(rf_sp)
    );

    cpu8_ctrl #(.NREGS(NREGS), .SP_IDX(SP_IDX)) u_ctrl (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(core_addr),
        .mem_we(core_we), .mem_wdata(core_wdata), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .rf_ra(rf_ra), .rf_rb(rf_rb), .rf_sp(rf_sp), .rf_we(rf_we),
        .rf_widx(rf_widx), .rf_wdata(rf_wdata), .print_valid(print_valid),
        .print_data(print_data), .halted(halted), .error(error)
    );

    assert_no_core_write_in_reset_R1: assert property (@(posedge clk)
        rst |-> !core_we);
endmodule

// File: tb/test_stack_cpu8.sv
module test_stack_cpu8;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_we = 1'b0;
    logic [7:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       print_valid, halted, error;
    logic [7:0] print_data;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    string cur_req = "R5";

    logic [7:0] prog [256];
    logic [7:0] exp_q [$];
    logic       exp_err;

    always #10 clk = ~clk;

    stack_cpu8 i_stack_cpu8 (
        .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .print_valid(print_valid), .print_data(print_data),
        .halted(halted), .error(error)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // compare every print against the reference queue
    always @(negedge clk) begin
        cycles++;
        if (!rst && print_valid) begin
            if (exp_q.size() == 0) begin
                vectors++; fails++;
                $display("FAIL R9: actual print %0d expected none", print_data);
            end else begin
                check(cur_req, print_data, exp_q.pop_front());
            end
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // behavioural instruction-level reference
    task automatic model();
        logic [7:0] m [256];
        logic [7:0] r [8];
        logic [7:0] pc, op, a, b;
        for (int i = 0; i < 256; i++) m[i] = prog[i];
        for (int i = 0; i < 8; i++) r[i] = 8'd0;
        r[7] = 8'hF4;
        pc = 0;
        exp_err = 1'b0;
        exp_q.delete();
        for (int step = 0; step < 500; step++) begin
            op = m[pc]; a = m[8'(pc + 1)]; b = m[8'(pc + 2)];
            if (op == 8'h82) r[a[2:0]] = b;
            else if (op == 8'h47) exp_q.push_back(r[a[2:0]]);
            else if (op == 8'hA2) r[a[2:0]] = 8'((r[a[2:0]] * r[b[2:0]]) & 255);
            else if (op == 8'h45) begin r[7] = r[7] - 1; m[r[7]] = r[a[2:0]]; end
            else if (op == 8'h46) begin r[a[2:0]] = m[r[7]]; r[7] = r[7] + 1; end
            else if (op == 8'h01) break;
            else begin exp_err = 1'b1; break; end
            pc = 8'(pc + 1 + op[7:6]);
        end
    endtask

    task automatic preload(logic [7:0] bytes [$]);
        for (int i = 0; i < 256; i++) prog[i] = (i < bytes.size()) ? bytes[i] : 8'h00;
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            load_we = 1'b1; load_addr = 8'(i); load_data = prog[i];
            @(negedge clk);
        end
        load_we = 1'b0;
    endtask

    task automatic execute(string req);
        int t;
        cur_req = req;
        model();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R2", {5'd0, halted, error, print_valid}, 8'd0);
        rst = 1'b0;
        t = 0;
        while (!halted && t < 3000) begin @(negedge clk); t++; end
        repeat (8) @(negedge clk);
        check("R9", {7'd0, halted}, 8'd1);
        check(exp_err ? "R10" : "R9", {7'd0, error}, {7'd0, exp_err});
        check(req, 8'(exp_q.size()), 8'd0);
        exp_q.delete();
    endtask

    initial begin
        // R4 R5 R9: print eight
        preload('{8'h82, 8'h00, 8'h08, 8'h47, 8'h00, 8'h01});
        execute("R4");
        // R1: preload while running is ignored; memory kept across reset
        load_we = 1'b1; load_addr = 8'd2; load_data = 8'd99;
        @(negedge clk);
        load_we = 1'b0;
        execute("R1");
        // R6 R3: multiply with and without overflow
        preload('{8'h82, 8'h00, 8'h08, 8'h82, 8'h01, 8'h09, 8'hA2, 8'h00, 8'h01,
                  8'h47, 8'h00, 8'h82, 8'h0A, 8'd20, 8'h82, 8'h03, 8'd20,
                  8'hA2, 8'h02, 8'h0B, 8'h47, 8'h02, 8'h01});
        execute("R6");
        // R7 R8: stack traffic, SP observed through print
        preload('{8'h82, 8'h00, 8'h01, 8'h82, 8'h01, 8'h02, 8'h45, 8'h00,
                  8'h45, 8'h01, 8'h47, 8'h07, 8'h82, 8'h00, 8'h03, 8'h46, 8'h00,
                  8'h47, 8'h00, 8'h46, 8'h02, 8'h47, 8'h02, 8'h47, 8'h07,
                  8'h45, 8'h07, 8'h46, 8'h03, 8'h47, 8'h03, 8'h01});
        execute("R7");
        // R8: pop reads data preloaded at the stack top
        preload('{8'h46, 8'h04, 8'h47, 8'h04, 8'h47, 8'h07, 8'h01});
        prog[8'hF4] = 8'd77;
        rst = 1'b1; load_we = 1'b1; load_addr = 8'hF4; load_data = 8'd77;
        @(negedge clk);
        load_we = 1'b0;
        execute("R8");
        // R10: unknown opcode stops before the following print
        preload('{8'h82, 8'h00, 8'h05, 8'hFF, 8'h47, 8'h00, 8'h01});
        execute("R10");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule